// File: doc/BRIEF.md
# Disk Task-File Register Device

This block is the drive side of a parallel disk interface, presented as a bank of byte-wide registers behind a port bus with 10-bit addresses. The host programs a sector count, a 28-bit logical block address and a drive/head byte. It then writes an opcode to the command port and follows the drive's BUSY, READY and DRQ status flags. While DRQ is up, it moves each 512-byte sector through the data port as 128 accesses of 32 bits each.

The storage medium is a small internal array of `NSEC` sectors, built so that block RAM can be inferred. Every command waits a fixed `LAT` cycles, and completion is reported through status, an error byte and an interrupt line. The interrupt fires once per sector and can be masked from the control register. A software reset in the control register returns the task file to its reset state. An error-injection input makes a command fail with an uncorrectable-data error.

Top module: `disk_taskfile`

## Requirements
- R1: After reset, status (0x1F7) reads 0x40 (bit 7 BUSY=0, bit 6 READY=1, bit 3 DRQ=0, bit 0 ERROR=0). The error byte (0x1F1) and the count, address and drive/head registers read 0x00, and irq_o is low.
- R2: Writes to 0x1F2 (count), 0x1F3/0x1F4/0x1F5 (address bits 7:0, 15:8, 23:16) and 0x1F6 (drive/head: bit 6 = LBA mode, bit 4 = drive, bits 3:0 = address 27:24) read back on io_rdata[7:0]. Read data is valid in the cycle after the read strobe is sampled.
- R3: Writing the command port while not busy sets BUSY and clears DRQ, ERROR and the error byte. BUSY stays set for exactly LAT cycles.
- R4: Opcode 0x30 (write) raises READY and DRQ (status 0x48) without an interrupt. After the 128th data-port write, DRQ falls and BUSY is set. LAT cycles later the interrupt is raised and status reads 0x40.
- R5: Opcode 0x20 (read) raises DRQ and the interrupt together after the latency. 128 data-port reads return the stored words in order. DRQ falls after the 128th read.
- R6: A count of N moves N consecutive sectors starting at the programmed address, with one interrupt per sector.
- R7: Reading status while not busy clears the pending interrupt. Control (0x3F6) bit 1 set masks irq_o without discarding the pending interrupt.
- R8: An unknown opcode, LBA mode bit clear, or drive bit set ends the command with status 0x41 and error byte 0x04 (abort, bit 2), and an interrupt.
- R9: An address at or beyond NSEC ends the command with status 0x41 and error byte 0x10 (ID not found, bit 4).
- R10: err_inject high when the command is written ends the command with status 0x41 and error byte 0x40 (uncorrectable, bit 6), and no DRQ.
- R11: A control write with bit 2 set returns status, error byte, interrupt and task registers to the R1 state, even mid-command.
- R12: Writes to task registers while BUSY are ignored. Data-port accesses without DRQ are ignored, and a data-port read without DRQ returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 32 | Write data (bits 7:0 for byte registers) |
| io_rdata | output | 32 | Read data, valid the cycle after io_rd |
| err_inject | input | 1 | Forces an uncorrectable error on the command being written |
| irq_o | output | 1 | Interrupt request, high while pending and unmasked |

## Verification
The checker monitors several rules on every cycle: BUSY and DRQ are never set together, a command write always yields BUSY, and a status read while idle always drops the interrupt. It also checks that the interrupt never coincides with BUSY and that the ERROR flag agrees with a nonzero error byte. Exact latency, the per-sector interrupt count, sector data order across multi-sector transfers, the error codes, masking that keeps a pending interrupt, and the ignored accesses are shown only by the bench's scenarios.

// File: rtl/disk_tf_pkg.sv
package disk_tf_pkg;
  localparam int AW = 10;
  localparam logic [AW-1:0] P_DATA = 10'h1F0;
  localparam logic [AW-1:0] P_ERR  = 10'h1F1;
  localparam logic [AW-1:0] P_CNT  = 10'h1F2;
  localparam logic [AW-1:0] P_LBA0 = 10'h1F3;
  localparam logic [AW-1:0] P_LBA1 = 10'h1F4;
  localparam logic [AW-1:0] P_LBA2 = 10'h1F5;
  localparam logic [AW-1:0] P_DH   = 10'h1F6;
  localparam logic [AW-1:0] P_CMD  = 10'h1F7;
  localparam logic [AW-1:0] P_CTRL = 10'h3F6;

  localparam logic [7:0] OP_RD = 8'h20;
  localparam logic [7:0] OP_WR = 8'h30;

  localparam logic [7:0] E_UNC  = 8'h40;
  localparam logic [7:0] E_IDNF = 8'h10;
  localparam logic [7:0] E_ABRT = 8'h04;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} seq_st_t;

  typedef struct packed {
    logic data;
    logic err;
    logic cnt;
    logic lba0;
    logic lba1;
    logic lba2;
    logic dh;
    logic cmd;
    logic ctrl;
  } tf_sel_t;
endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
  import disk_tf_pkg::*;
(
  input  logic [AW-1:0] addr,
  output tf_sel_t       sel
);
  always_comb begin
    sel      = '0;
    sel.data = (addr == P_DATA);
    sel.err  = (addr == P_ERR);
    sel.cnt  = (addr == P_CNT);
    sel.lba0 = (addr == P_LBA0);
    sel.lba1 = (addr == P_LBA1);
    sel.lba2 = (addr == P_LBA2);
    sel.dh   = (addr == P_DH);
    sel.cmd  = (addr == P_CMD);
    sel.ctrl = (addr == P_CTRL);
  end
endmodule

// File: rtl/tf_medium.sv
module tf_medium #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/tf_seq.sv
module tf_seq
  import disk_tf_pkg::*;
#(
  parameter int NSEC = 4,
  parameter int LAT  = 8,
  parameter int WPS  = 128,
  localparam int PW  = $clog2(WPS),
  localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int LCW = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             cmd_we,
  input  logic [7:0]       cmd,
  input  logic [27:0]      lba,
  input  logic             lba_mode,
  input  logic             drv,
  input  logic [7:0]       cnt,
  input  logic             inject,
  input  logic             stat_rd,
  input  logic             data_rd,
  input  logic             data_wr,
  output logic             bsy,
  output logic             drq,
  output logic             err,
  output logic [7:0]       err_byte,
  output logic             pend,
  output logic [SW+PW-1:0] mem_addr
);
  seq_st_t        st_q;
  logic [LCW-1:0] lat_q;
  logic [PW-1:0]  ptr_q;
  logic [7:0]     left_q;
  logic [27:0]    lba_q;
  logic           wr_mode_q, armed_q, bad_q, inj_q;

  wire xfer_hit = wr_mode_q ? data_wr : data_rd;
  wire last_wd  = (ptr_q == PW'(WPS - 1));
  wire last_sec = (left_q == 8'd1);

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      st_q <= S_IDLE; lat_q <= '0; ptr_q <= '0; left_q <= '0; lba_q <= '0;
      wr_mode_q <= 1'b0; armed_q <= 1'b0; bad_q <= 1'b0; inj_q <= 1'b0;
      bsy <= 1'b0; drq <= 1'b0; err <= 1'b0; err_byte <= '0; pend <= 1'b0;
    end else begin
      if (stat_rd) pend <= 1'b0;
      if (cmd_we) begin
        st_q <= S_WAIT; lat_q <= LCW'(LAT - 1); ptr_q <= '0;
        bsy <= 1'b1; drq <= 1'b0; err <= 1'b0; err_byte <= '0; pend <= 1'b0;
        wr_mode_q <= (cmd == OP_WR); armed_q <= 1'b0;
        bad_q <= !((cmd == OP_RD) || (cmd == OP_WR)) || !lba_mode || drv;
        inj_q <= inject; lba_q <= lba; left_q <= cnt;
      end else begin
        case (st_q)
          S_WAIT: begin
            if (lat_q != '0) begin
              lat_q <= lat_q - 1'b1;
            end else begin
              bsy <= 1'b0;
              if (bad_q || (lba_q >= 28'(NSEC)) || inj_q) begin
                err <= 1'b1; pend <= 1'b1; st_q <= S_IDLE;
                err_byte <= bad_q ? E_ABRT : (lba_q >= 28'(NSEC)) ? E_IDNF : E_UNC;
              end else if (!wr_mode_q) begin
                drq <= 1'b1; pend <= 1'b1; st_q <= S_XFER;
              end else if (!armed_q) begin
                drq <= 1'b1; st_q <= S_XFER;
              end else begin
                pend <= 1'b1;
                if (last_sec) begin
                  st_q <= S_IDLE;
                end else begin
                  left_q <= left_q - 1'b1; lba_q <= lba_q + 1'b1;
                  drq <= 1'b1; st_q <= S_XFER;
                end
              end
            end
          end
          S_XFER: begin
            if (xfer_hit) begin
              ptr_q <= ptr_q + 1'b1;
              if (last_wd) begin
                drq <= 1'b0;
                if (wr_mode_q) begin
                  bsy <= 1'b1; armed_q <= 1'b1; lat_q <= LCW'(LAT - 1);
                  pend <= 1'b0; st_q <= S_WAIT;
                end else if (last_sec) begin
                  st_q <= S_IDLE;
                end else begin
                  left_q <= left_q - 1'b1; lba_q <= lba_q + 1'b1;
                  bsy <= 1'b1; lat_q <= LCW'(LAT - 1); pend <= 1'b0; st_q <= S_WAIT;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_addr = {lba_q[SW-1:0], ptr_q};
endmodule

// File: rtl/disk_taskfile.sv
module disk_taskfile
  import disk_tf_pkg::*;
#(
  parameter int NSEC = 4,
  parameter int LAT  = 8,
  parameter int WPS  = 128,
  localparam int MAW = ((NSEC > 1) ? $clog2(NSEC) : 1) + $clog2(WPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  input  logic          err_inject,
  output logic          irq_o
);
  tf_sel_t        sel;
  logic [7:0]     cnt_q, lba0_q, lba1_q, lba2_q, dh_q;
  logic           nien_q;
  logic           bsy, drq, err, pend;
  logic [7:0]     err_byte, stat, rd_q;
  logic           msel_q;
  logic [MAW-1:0] mem_addr;
  logic [31:0]    mem_q;

  tf_addr_decode u_dec (.addr(io_addr), .sel(sel));

  wire srst    = io_wr && sel.ctrl && io_wdata[2];
  wire cmd_we  = io_wr && sel.cmd && !bsy;
  wire tf_we   = io_wr && !bsy;
  wire data_rd = io_rd && sel.data && drq;
  wire data_wr = io_wr && sel.data && drq;
  wire stat_rd = io_rd && sel.cmd;

  assign stat = {bsy, !bsy, 2'b00, drq, 2'b00, err};

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      cnt_q <= '0; lba0_q <= '0; lba1_q <= '0; lba2_q <= '0; dh_q <= '0;
    end else if (tf_we) begin
      if (sel.cnt)  cnt_q  <= io_wdata[7:0];
      if (sel.lba0) lba0_q <= io_wdata[7:0];
      if (sel.lba1) lba1_q <= io_wdata[7:0];
      if (sel.lba2) lba2_q <= io_wdata[7:0];
      if (sel.dh)   dh_q   <= io_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) nien_q <= 1'b0;
    else if (io_wr && sel.ctrl) nien_q <= io_wdata[1];
  end

  tf_seq #(.NSEC(NSEC), .LAT(LAT), .WPS(WPS)) u_seq (
    .clk(clk), .rst(rst), .srst(srst), .cmd_we(cmd_we), .cmd(io_wdata[7:0]),
    .lba({dh_q[3:0], lba2_q, lba1_q, lba0_q}), .lba_mode(dh_q[6]), .drv(dh_q[4]),
    .cnt(cnt_q), .inject(err_inject), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .bsy(bsy), .drq(drq), .err(err), .err_byte(err_byte),
    .pend(pend), .mem_addr(mem_addr)
  );

  tf_medium #(.AW(MAW), .DW(32)) u_mem (
    .clk(clk), .we(data_wr), .re(data_rd), .addr(mem_addr),
    .wdata(io_wdata), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0; msel_q <= 1'b0;
    end else if (io_rd) begin
      msel_q <= data_rd;
      unique case (1'b1)
        sel.err:  rd_q <= err_byte;
        sel.cnt:  rd_q <= cnt_q;
        sel.lba0: rd_q <= lba0_q;
        sel.lba1: rd_q <= lba1_q;
        sel.lba2: rd_q <= lba2_q;
        sel.dh:   rd_q <= dh_q;
        sel.cmd:  rd_q <= stat;
        default:  rd_q <= '0;
      endcase
    end
  end

  assign io_rdata = msel_q ? mem_q : {24'h0, rd_q};
  assign irq_o    = pend && !nien_q;
endmodule

// File: rtl/disk_taskfile_chk.sv
module disk_taskfile_chk
  import disk_tf_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    stat,
  input logic [7:0]    err_byte,
  input logic          irq_o
);
  // R3: busy and data request never together
  p_bsy_drq_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(stat[7] && stat[3]));

  // R3: an accepted command write makes the drive busy
  p_cmd_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == P_CMD && !stat[7]) |=> stat[7]);

  // R7: status read while idle drops the interrupt
  p_stat_clr_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == P_CMD && !stat[7]) |=> !irq_o);

  // R6: an interrupt is only presented while not busy
  p_irq_idle_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> !stat[7]);

  // R8: error flag agrees with a nonzero error byte
  p_err_byte_r8: assert property (@(posedge clk) disable iff (rst)
    stat[0] == (err_byte != 8'h00));
endmodule

bind disk_taskfile disk_taskfile_chk u_chk (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .stat(stat), .err_byte(err_byte), .irq_o(irq_o)
);

// File: tb/tb_disk_taskfile.sv
module tb_disk_taskfile;
  localparam int NSEC = 4;
  localparam int LAT  = 8;
  localparam int WPS  = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        err_inject = 1'b0;
  logic        irq_o;
  int n_chk = 0, n_err = 0;
  logic [31:0] d;

  always #10 clk = ~clk;

  disk_taskfile #(.NSEC(NSEC), .LAT(LAT), .WPS(WPS)) dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .err_inject(err_inject), .irq_o(irq_o)
  );

  // address/data pairs for register readback (R2)
  localparam logic [17:0] VEC [6] = '{
    {10'h1F2, 8'h03}, {10'h1F3, 8'h5A}, {10'h1F4, 8'hC3},
    {10'h1F5, 8'h7E}, {10'h1F6, 8'hE9}, {10'h1F3, 8'h01}
  };

  function automatic logic [31:0] pat(input int lba, input int i);
    return 32'h5EED0000 ^ (32'(lba) << 24) ^ (32'(i) * 32'h00010203);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk); io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; v = io_rdata;
  endtask

  task automatic setup(input int lba, input logic [7:0] cnt, input logic [7:0] dh);
    wr(10'h1F2, 32'(cnt));
    wr(10'h1F3, 32'(lba & 8'hFF));
    wr(10'h1F4, 32'((lba >> 8) & 8'hFF));
    wr(10'h1F5, 32'((lba >> 16) & 8'hFF));
    wr(10'h1F6, 32'(dh | 8'((lba >> 24) & 4'hF)));
  endtask

  task automatic settle();
    repeat (LAT + 3) @(negedge clk);
  endtask

  task automatic read_sector(input string req, input int lba);
    logic [31:0] v;
    for (int i = 0; i < WPS; i++) begin
      rd(10'h1F0, v);
      check(req, v, pat(lba, i));
    end
  endtask

  task automatic fill_sector(input int lba);
    for (int i = 0; i < WPS; i++) wr(10'h1F0, pat(lba, i));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    rd(10'h1F7, d); check("R1 status", d, 32'h40);
    rd(10'h1F1, d); check("R1 error", d, 0);
    rd(10'h1F2, d); check("R1 count", d, 0);
    rd(10'h1F6, d); check("R1 drive/head", d, 0);

    // R2 register table
    foreach (VEC[k]) begin
      wr(VEC[k][17:8], 32'(VEC[k][7:0]));
      rd(VEC[k][17:8], d);
      check("R2 readback", d, 32'(VEC[k][7:0]));
    end

    // R4 single-sector write
    setup(1, 8'd1, 8'hE0);
    wr(10'h1F7, 32'h30);
    settle();
    check("R4 no irq on data request", 32'(irq_o), 0);
    rd(10'h1F7, d); check("R4 drq status", d, 32'h48);
    fill_sector(1);
    rd(10'h1F7, d); check("R4 busy after last word", d, 32'h80);
    settle();
    check("R4 irq after write", 32'(irq_o), 1);
    rd(10'h1F7, d); check("R4 final status", d, 32'h40);
    check("R7 irq cleared by status read", 32'(irq_o), 0);

    // R6 two-sector write at 2,3
    setup(2, 8'd2, 8'hE0);
    wr(10'h1F7, 32'h30);
    settle();
    rd(10'h1F7, d); check("R6 first drq", d, 32'h48);
    fill_sector(2);
    settle();
    check("R6 irq sector 1", 32'(irq_o), 1);
    rd(10'h1F7, d); check("R6 second drq", d, 32'h48);
    fill_sector(3);
    settle();
    check("R6 irq sector 2", 32'(irq_o), 1);
    rd(10'h1F7, d); check("R6 write done", d, 32'h40);

    // R3 exact latency, R5 read
    setup(1, 8'd1, 8'hE0);
    wr(10'h1F7, 32'h20);
    repeat (LAT - 2) @(negedge clk);
    rd(10'h1F7, d); check("R3 busy through latency", d, 32'h80);
    check("R5 irq with data", 32'(irq_o), 1);
    rd(10'h1F7, d); check("R3 busy cleared after LAT", d, 32'h48);
    read_sector("R5 data", 1);
    rd(10'h1F7, d); check("R5 drq fell", d, 32'h40);

    // R6 two-sector read
    setup(2, 8'd2, 8'hE0);
    wr(10'h1F7, 32'h20);
    for (int s = 2; s < 4; s++) begin
      settle();
      check("R6 irq per sector", 32'(irq_o), 1);
      rd(10'h1F7, d); check("R6 read drq", d, 32'h48);
      read_sector("R6 data", s);
    end
    rd(10'h1F7, d); check("R6 read done", d, 32'h40);

    // R7 masking keeps pending
    wr(10'h3F6, 32'h02);
    setup(1, 8'd1, 8'hE0);
    wr(10'h1F7, 32'h20);
    settle();
    check("R7 masked", 32'(irq_o), 0);
    wr(10'h3F6, 32'h00);
    check("R7 unmasked pending", 32'(irq_o), 1);

    // R11 software reset mid-command
    wr(10'h3F6, 32'h04);
    check("R11 irq", 32'(irq_o), 0);
    rd(10'h1F7, d); check("R11 status", d, 32'h40);
    rd(10'h1F2, d); check("R11 count", d, 0);
    rd(10'h1F0, d); check("R11 no drq data", d, 0);

    // R8 aborts
    setup(1, 8'd1, 8'hE0);
    wr(10'h1F7, 32'hEE);
    settle();
    check("R8 irq", 32'(irq_o), 1);
    rd(10'h1F7, d); check("R8 opcode status", d, 32'h41);
    rd(10'h1F1, d); check("R8 opcode error", d, 32'h04);
    setup(1, 8'd1, 8'hF0);
    wr(10'h1F7, 32'h20);
    settle();
    rd(10'h1F1, d); check("R8 drive 1 error", d, 32'h04);
    setup(1, 8'd1, 8'hA0);
    wr(10'h1F7, 32'h20);
    settle();
    rd(10'h1F1, d); check("R8 no lba mode error", d, 32'h04);

    // R9 out of range
    setup(NSEC, 8'd1, 8'hE0);
    wr(10'h1F7, 32'h20);
    settle();
    rd(10'h1F7, d); check("R9 status", d, 32'h41);
    rd(10'h1F1, d); check("R9 error", d, 32'h10);

    // R10 injected error
    setup(1, 8'd1, 8'hE0);
    err_inject = 1'b1;
    wr(10'h1F7, 32'h20);
    err_inject = 1'b0;
    settle();
    rd(10'h1F7, d); check("R10 status", d, 32'h41);
    rd(10'h1F1, d); check("R10 error", d, 32'h40);

    // R12 writes during busy ignored; R3 error cleared by new command
    wr(10'h1F7, 32'h20);
    wr(10'h1F3, 32'h77);
    settle();
    rd(10'h1F3, d); check("R12 busy write ignored", d, 32'h01);
    rd(10'h1F7, d); check("R3 error cleared", d, 32'h48);
    read_sector("R12 data intact", 1);
    wr(10'h1F0, 32'hDEADBEEF);
    rd(10'h1F0, d); check("R12 data read without drq", d, 0);
    wr(10'h1F7, 32'h20);
    settle();
    rd(10'h1F7, d);
    rd(10'h1F0, d); check("R12 stray write not stored", d, pat(1, 0));

    summary();
  end
endmodule